// File: doc/BRIEF.md
# Power-Management Event Status and Enable Registers

This block holds a 16-bit event status register and a 16-bit event enable register. Both sit behind a small byte-addressed access port of four bytes. Four hardware sources can record an event in the status register: a toggle of the PM timer's most significant bit, a global event, a power-button press and a sleep-button press. Software reads the status to learn which event happened. It clears each event by writing a one to its bit. It selects which events may interrupt by writing the enable register.

A single level-sensitive system control interrupt output is high whenever an enabled event is pending. It is computed from the register contents, so it follows every register update, whether that update comes from an access or from an event. Accesses may be one, two or four bytes wide and may start at any offset from 0 to 3. A multi-byte write is split into byte lanes that land on consecutive offsets.

Top module: `pm1_evt_regs`

## Requirements
- R1: While reset is active, and after it is released, both registers read zero and `sci_o` is low until an event sets a bit.
- R2: `sci_o` is high exactly when `enable & status & 16'h0321` is nonzero. It reflects the registers written at the previous clock edge.
- R3: Status bit 0 holds the timer-MSB event, bit 5 the global event, bit 8 the power button and bit 9 the sleep button. The enable register uses the same positions. All other status bits always read zero.
- R4: Byte offset 0 is status[7:0], offset 1 is status[15:8], offset 2 is enable[7:0] and offset 3 is enable[15:8].
- R5: A write to a status byte clears each bit written as 1 and leaves every bit written as 0 unchanged.
- R6: A write to an enable byte replaces that byte and leaves the other enable byte unchanged.
- R7: `acc_size_i` encodes 0 as 1 byte, 1 as 2 bytes, and 2 or 3 as 4 bytes. Data byte k (`acc_wdata_i[8k+7:8k]`) is written to offset start+k.
- R8: `acc_rdata_o` is `{enable, status}` shifted right by 8 × start offset. It is masked to 8 bits for size 0 and to 16 bits for size 1. It is zero when no read is presented.
- R9: A one-cycle pulse on `pwrbtn_i`, `slpbtn_i`, `gbl_evt_i` or `tmr_msb_i` sets its status bit at the next clock edge. `sci_o` updates in the same cycle as that bit.
- R10: Write bytes that fall on offsets 4 or higher are ignored. This holds both for writes that start there and for the trailing lanes of a wide write.
- R11: If an event pulse and a software clear of the same status bit happen in the same cycle, the bit ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| acc_valid_i | input | 1 | Access strobe, one cycle per access |
| acc_write_i | input | 1 | 1 = write, 0 = read |
| acc_addr_i | input | 3 | Start byte offset |
| acc_size_i | input | 2 | Access size code (see R7) |
| acc_wdata_i | input | 32 | Write data, byte 0 goes to the start offset |
| acc_rdata_o | output | 32 | Read data, combinational from the registers |
| tmr_msb_i | input | 1 | Timer most-significant-bit toggle pulse |
| gbl_evt_i | input | 1 | Global event pulse |
| pwrbtn_i | input | 1 | Power-button pulse |
| slpbtn_i | input | 1 | Sleep-button pulse |
| sci_o | output | 1 | Level system control interrupt |

## Verification
Two functions can act on the same status bit in one cycle: an event pulse that sets it and a software write that clears it. The bench provokes this collision directly for the power-button bit. It also lets it occur freely in a random run, where event pulses and write-one-to-clear writes are drawn independently each cycle. A reference model applies the clear first and the event second. After every cycle the bench compares the interrupt level and a random read against that model.

// File: rtl/pm1_pkg.sv
package pm1_pkg;
  localparam int unsigned BIT_TMR = 0;
  localparam int unsigned BIT_GBL = 5;
  localparam int unsigned BIT_PWR = 8;
  localparam int unsigned BIT_SLP = 9;

  localparam logic [15:0] SCI_SRC_MASK = (16'd1 << BIT_TMR) | (16'd1 << BIT_GBL) |
                                         (16'd1 << BIT_PWR) | (16'd1 << BIT_SLP);

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_HALF  = 2'd1,
    SZ_WORD  = 2'd2,
    SZ_WORD3 = 2'd3
  } acc_size_e;
endpackage

// File: rtl/pm1_lane_decode.sv
module pm1_lane_decode #(
  parameter int unsigned ADDR_W    = 3,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned NUM_LANES = DATA_W / 8
) (
  input  logic                      wr_stb_i,
  input  logic [ADDR_W-1:0]         addr_i,
  input  logic [1:0]                size_i,
  input  logic [DATA_W-1:0]         wdata_i,
  output logic [NUM_LANES-1:0]      lane_we_o,
  output logic [NUM_LANES-1:0][7:0] lane_byte_o
);
  import pm1_pkg::*;

  localparam int unsigned CNT_W = ADDR_W + 1;

  logic [CNT_W-1:0] nbytes;
  logic [CNT_W-1:0] start;

  always_comb begin
    start = {1'b0, addr_i};
    unique case (acc_size_e'(size_i))
      SZ_BYTE: nbytes = CNT_W'(1);
      SZ_HALF: nbytes = CNT_W'(2);
      default: nbytes = CNT_W'(4);
    endcase
  end

  for (genvar j = 0; j < NUM_LANES; j++) begin : g_lane
    localparam logic [CNT_W-1:0] LANE = CNT_W'(j);
    logic [CNT_W-1:0]  rel;
    logic [DATA_W-1:0] shifted;
    always_comb begin
      rel            = LANE - start;
      shifted        = wdata_i >> {rel, 3'b000};
      lane_we_o[j]   = wr_stb_i && (start <= LANE) && (rel < nbytes);
      lane_byte_o[j] = shifted[7:0];
    end
  end
endmodule

// File: rtl/pm1_status_reg.sv
module pm1_status_reg #(
  parameter int unsigned REG_W = 16,
  parameter int unsigned LANES = REG_W / 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [LANES-1:0]      clr_we_i,
  input  logic [LANES-1:0][7:0] clr_byte_i,
  input  logic [REG_W-1:0]      set_i,
  output logic [REG_W-1:0]      sts_q
);
  import pm1_pkg::*;

  localparam logic [REG_W-1:0] MASK = REG_W'(SCI_SRC_MASK);

  logic [REG_W-1:0] clr_mask;
  logic [REG_W-1:0] set_m;
  logic [REG_W-1:0] sts_d;
  logic             sts_ce;

  for (genvar l = 0; l < LANES; l++) begin : g_clr
    assign clr_mask[8*l +: 8] = clr_we_i[l] ? clr_byte_i[l] : 8'h00;
  end

  always_comb begin
    set_m  = set_i & MASK;
    sts_d  = (sts_q & ~clr_mask) | set_m;
    sts_ce = (|clr_we_i) || (|set_m);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sts_q <= '0;
    else if (sts_ce) sts_q <= sts_d;
  end

  a_r5_clear_never_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (set_m == '0) |=> ((sts_q & ~$past(sts_q)) == '0));

  a_r11_event_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (set_m != '0) |=> ((sts_q & $past(set_m)) == $past(set_m)));

  a_r3_only_source_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_q & ~MASK) == '0);
endmodule

// File: rtl/pm1_enable_reg.sv
module pm1_enable_reg #(
  parameter int unsigned REG_W = 16,
  parameter int unsigned LANES = REG_W / 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [LANES-1:0]      we_i,
  input  logic [LANES-1:0][7:0] byte_i,
  output logic [REG_W-1:0]      en_q
);
  for (genvar l = 0; l < LANES; l++) begin : g_byte
    logic [7:0] byte_d;
    logic [7:0] byte_q;

    always_comb byte_d = byte_i[l];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        byte_q <= 8'h00;
      else if (we_i[l])  byte_q <= byte_d;
    end

    assign en_q[8*l +: 8] = byte_q;

    a_r6_untouched_lane_kept: assert property (@(posedge clk) disable iff (!rst_n)
      !we_i[l] |=> (en_q[8*l +: 8] == $past(en_q[8*l +: 8])));
  end
endmodule

// File: rtl/pm1_evt_regs.sv
module pm1_evt_regs #(
  parameter int unsigned ADDR_W = 3,
  parameter int unsigned REG_W  = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                acc_valid_i,
  input  logic                acc_write_i,
  input  logic [ADDR_W-1:0]   acc_addr_i,
  input  logic [1:0]          acc_size_i,
  input  logic [2*REG_W-1:0]  acc_wdata_i,
  output logic [2*REG_W-1:0]  acc_rdata_o,
  input  logic                tmr_msb_i,
  input  logic                gbl_evt_i,
  input  logic                pwrbtn_i,
  input  logic                slpbtn_i,
  output logic                sci_o
);
  import pm1_pkg::*;

  localparam int unsigned DATA_W    = 2 * REG_W;
  localparam int unsigned REG_LANES = REG_W / 8;
  localparam int unsigned NUM_LANES = DATA_W / 8;
  localparam logic [REG_W-1:0] MASK = REG_W'(SCI_SRC_MASK);

  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  logic                      wr_stb;
  logic [NUM_LANES-1:0]      lane_we;
  logic [NUM_LANES-1:0][7:0] lane_byte;

  assign wr_stb = acc_valid_i && acc_write_i;

  pm1_lane_decode #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .NUM_LANES (NUM_LANES)
  ) u_decode (
    .wr_stb_i    (wr_stb),
    .addr_i      (acc_addr_i),
    .size_i      (acc_size_i),
    .wdata_i     (acc_wdata_i),
    .lane_we_o   (lane_we),
    .lane_byte_o (lane_byte)
  );

  logic [REG_W-1:0] set_vec;
  always_comb begin
    set_vec          = '0;
    set_vec[BIT_TMR] = tmr_msb_i;
    set_vec[BIT_GBL] = gbl_evt_i;
    set_vec[BIT_PWR] = pwrbtn_i;
    set_vec[BIT_SLP] = slpbtn_i;
  end

  logic [REG_W-1:0] sts_q;
  logic [REG_W-1:0] en_q;

  pm1_status_reg #(.REG_W(REG_W), .LANES(REG_LANES)) u_status (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .clr_we_i   (lane_we[REG_LANES-1:0]),
    .clr_byte_i (lane_byte[REG_LANES-1:0]),
    .set_i      (set_vec),
    .sts_q      (sts_q)
  );

  pm1_enable_reg #(.REG_W(REG_W), .LANES(REG_LANES)) u_enable (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .we_i   (lane_we[NUM_LANES-1:REG_LANES]),
    .byte_i (lane_byte[NUM_LANES-1:REG_LANES]),
    .en_q   (en_q)
  );

  logic [DATA_W-1:0] rd_word;
  logic [DATA_W-1:0] rd_shift;
  always_comb begin
    rd_word  = {en_q, sts_q};
    rd_shift = rd_word >> {acc_addr_i, 3'b000};
    unique case (acc_size_e'(acc_size_i))
      SZ_BYTE: rd_shift = rd_shift & DATA_W'(8'hFF);
      SZ_HALF: rd_shift = rd_shift & DATA_W'(16'hFFFF);
      default: ;
    endcase
    acc_rdata_o = (acc_valid_i && !acc_write_i) ? rd_shift : '0;
  end

  assign sci_o = |(en_q & sts_q & MASK);

  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_sync_n |-> (!sci_o && sts_q == '0 && en_q == '0));

  a_r2_sci_rise_cause: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(sci_o) |-> $past((|set_vec) || (|lane_we[NUM_LANES-1:REG_LANES])));

  a_r2_sci_fall_cause: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $fell(sci_o) |-> $past(wr_stb));

  a_r10_high_offsets_idle: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_stb && acc_addr_i >= ADDR_W'(NUM_LANES)) |-> (lane_we == '0));
endmodule

// File: tb/tb_pm1_evt_regs.sv
module tb_pm1_evt_regs;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        acc_valid_i, acc_write_i;
  logic [2:0]  acc_addr_i;
  logic [1:0]  acc_size_i;
  logic [31:0] acc_wdata_i, acc_rdata_o;
  logic        tmr_msb_i, gbl_evt_i, pwrbtn_i, slpbtn_i, sci_o;

  int checks = 0;
  int fails  = 0;
  logic [15:0] m_sts, m_en;

  always #4 clk = ~clk;

  pm1_evt_regs dut (
    .clk(clk), .rst_n(rst_n), .acc_valid_i(acc_valid_i), .acc_write_i(acc_write_i),
    .acc_addr_i(acc_addr_i), .acc_size_i(acc_size_i), .acc_wdata_i(acc_wdata_i),
    .acc_rdata_o(acc_rdata_o), .tmr_msb_i(tmr_msb_i), .gbl_evt_i(gbl_evt_i),
    .pwrbtn_i(pwrbtn_i), .slpbtn_i(slpbtn_i), .sci_o(sci_o)
  );

  function automatic int nbytes(input logic [1:0] sz);
    return (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4;
  endfunction

  function automatic logic [31:0] exp_read(input logic [2:0] a, input logic [1:0] sz);
    logic [31:0] w;
    w = (a >= 3'd4) ? 32'h0 : ({m_en, m_sts} >> (8 * a));
    if (sz == 2'd0) w &= 32'hFF;
    else if (sz == 2'd1) w &= 32'hFFFF;
    return w;
  endfunction

  function automatic logic exp_sci();
    return |(m_en & m_sts & 16'h0321);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic model_write(input logic [2:0] a, input logic [1:0] sz, input logic [31:0] d);
    for (int k = 0; k < nbytes(sz); k++) begin
      int off = int'(a) + k;
      logic [7:0] b = d[8*k +: 8];
      case (off)
        0: m_sts &= ~{8'h00, b};
        1: m_sts &= ~{b, 8'h00};
        2: m_en[7:0] = b;
        3: m_en[15:8] = b;
        default: ;
      endcase
    end
  endtask

  // ev = {sleep, power, global, timer}
  task automatic step(input logic wr, input logic [2:0] a, input logic [1:0] sz,
                      input logic [31:0] d, input logic [3:0] ev);
    @(negedge clk);
    acc_valid_i = wr; acc_write_i = wr; acc_addr_i = a; acc_size_i = sz; acc_wdata_i = d;
    {slpbtn_i, pwrbtn_i, gbl_evt_i, tmr_msb_i} = ev;
    @(posedge clk);
    if (wr) model_write(a, sz, d);
    if (ev[0]) m_sts[0] = 1'b1;
    if (ev[1]) m_sts[5] = 1'b1;
    if (ev[2]) m_sts[8] = 1'b1;
    if (ev[3]) m_sts[9] = 1'b1;
    @(negedge clk);
    acc_valid_i = 1'b0; acc_write_i = 1'b0;
    {slpbtn_i, pwrbtn_i, gbl_evt_i, tmr_msb_i} = 4'h0;
    #1;
    chk("R2 sci level", {31'h0, sci_o}, {31'h0, exp_sci()});
  endtask

  task automatic rd(input string req, input logic [2:0] a, input logic [1:0] sz);
    acc_valid_i = 1'b1; acc_write_i = 1'b0; acc_addr_i = a; acc_size_i = sz;
    #1;
    chk(req, acc_rdata_o, exp_read(a, sz));
    acc_valid_i = 1'b0;
    #1;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd2024));
    rst_n = 1'b0;
    acc_valid_i = 0; acc_write_i = 0; acc_addr_i = 0; acc_size_i = 0; acc_wdata_i = 0;
    tmr_msb_i = 0; gbl_evt_i = 0; pwrbtn_i = 0; slpbtn_i = 0;
    m_sts = 0; m_en = 0;
    repeat (4) @(negedge clk);
    #1;
    chk("R1 sci in reset", {31'h0, sci_o}, 32'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    rd("R1 registers zero after reset", 3'd0, 2'd2);
    chk("R1 sci after reset", {31'h0, sci_o}, 32'h0);

    // R9 event without enable: status set, no interrupt
    step(1'b0, 3'd0, 2'd0, 32'h0, 4'b0100);
    rd("R9 power button sets bit 8", 3'd0, 2'd1);
    rd("R3 status high byte", 3'd1, 2'd0);
    // R4/R6 enable write via two bytes at offset 2
    step(1'b1, 3'd2, 2'd1, 32'h0000_0121, 4'h0);
    chk("R2 sci after enable", {31'h0, sci_o}, 32'h1);
    rd("R4 enable at offset 2", 3'd2, 2'd1);
    // R6 single byte keeps other byte
    step(1'b1, 3'd3, 2'd0, 32'h0000_0002, 4'h0);
    rd("R6 enable byte kept", 3'd2, 2'd1);
    // R5 clear bit 8 with a one at offset 1 bit 0
    step(1'b1, 3'd1, 2'd0, 32'h0000_0001, 4'h0);
    rd("R5 write one clears", 3'd0, 2'd1);
    // R3 all four sources
    step(1'b0, 3'd0, 2'd0, 32'h0, 4'b1111);
    rd("R3 source bit positions", 3'd0, 2'd2);
    // R11 event and clear same cycle on bit 8
    step(1'b1, 3'd0, 2'd1, 32'h0000_0100, 4'b0100);
    rd("R11 event wins over clear", 3'd0, 2'd1);
    // R7 word write at offset 2: bytes 2,3 land in enable, rest dropped
    step(1'b1, 3'd2, 2'd2, 32'hFFFF_0320, 4'h0);
    rd("R7 wide write lanes", 3'd0, 2'd2);
    // R10 write starting at offset 5 ignored
    step(1'b1, 3'd5, 2'd2, 32'hFFFF_FFFF, 4'h0);
    rd("R10 high offset write ignored", 3'd0, 2'd2);
    // R8 read alignments
    rd("R8 read offset 3 half", 3'd3, 2'd1);
    rd("R8 read offset 1 word", 3'd1, 2'd2);
    rd("R8 read offset 6", 3'd6, 2'd2);
    // R5 full clear drops sci
    step(1'b1, 3'd0, 2'd1, 32'h0000_FFFF, 4'h0);
    rd("R5 full clear", 3'd0, 2'd2);

    for (int i = 0; i < 600; i++) begin
      logic        wr = ($urandom % 2) == 0;
      logic [2:0]  a  = 3'($urandom % 6);
      logic [1:0]  sz = 2'($urandom % 4);
      logic [31:0] d  = $urandom;
      logic [3:0]  ev = (($urandom % 3) == 0) ? 4'($urandom) : 4'h0;
      step(wr, a, sz, d, ev);
      rd("R8 random read", 3'($urandom % 8), 2'($urandom % 4));
    end

    finish_run();
  end
endmodule